// File: doc/BRIEF.md
# Retention Tracker with Staggered Refresh

This block watches every physical flash block for loss of retention. A block written in the relaxed-retention mode keeps its data for only a limited time. The checking period is set to half of that time. Each block has a small state entry. The first page written to an idle block in relaxed mode marks it fresh. A periodic tick starts a scan that walks the entries one index per cycle. The scan ages each fresh entry to due. Because a relaxed block written during period n must be moved during period n+1, one bit of age per block is enough; the remaining encodings record whether the block is idle or already handed off.

Due blocks are handed to a background mover one at a time, lowest index first, over a valid/ready request. Consecutive requests are spread apart by a fixed stagger interval, counted in clock cycles, so that refresh traffic never arrives as a burst. After the mover has copied the live data, an erase or invalidate completion for the old block returns its entry to idle. If a scan finds a block that is still waiting for its move, the deadline has been missed and a sticky error flag is raised. Blocks written in the normal mode are never scheduled.

Top module: `retention_tracker`

## Requirements
- R1: After reset, req_valid and ovf_err are 0 and every entry is idle, so a period tick with no prior write raises no request.
- R2: A write with wr_valid=1, wr_first=1 and wr_relaxed=1 to an idle block marks it fresh; a fresh block raises no request before the next period tick.
- R3: Writes with wr_relaxed=0 (normal mode) or wr_first=0 (not the first page) change no entry, so their blocks are never requested.
- R4: A period tick at clock edge t starts a scan; the entry of block i is examined at edge t+1+i, and a fresh entry becomes due. Due blocks are requested one at a time in ascending index order. req_blk stays stable while req_valid=1 and req_ready=0, and req_valid drops after the handshake edge.
- R5: When due blocks are waiting, req_valid rises exactly STAGGER_CYCLES cycles after the edge of the previous handshake, and never earlier.
- R6: rel_valid=1 with index rel_blk returns that entry to idle, whatever its state; a released block raises no request.
- R7: A scan that examines a block which is due or handed off sets ovf_err. ovf_err stays at 1 until err_clear=1 is seen, and it is 0 after that edge unless a new miss happens in the same cycle.
- R8: When a first-page relaxed write for block i arrives in the same cycle in which the scan examines block i, the write takes priority and the scan step for that index is skipped, so a fresh block stays fresh until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_tick | input | 1 | One-cycle pulse at the end of each checking period |
| wr_valid | input | 1 | Block write event |
| wr_blk | input | IDX_W | Block index of the write |
| wr_first | input | 1 | The write is to the first page of the block |
| wr_relaxed | input | 1 | 1 = relaxed-retention mode, 0 = normal mode |
| rel_valid | input | 1 | Erase or invalidate of a block has completed |
| rel_blk | input | IDX_W | Block index of the completion |
| req_ready | input | 1 | The mover accepts the current request |
| err_clear | input | 1 | Clears the overflow flag |
| req_valid | output | 1 | A reprogram request is offered |
| req_blk | output | IDX_W | Block to be reprogrammed |
| ovf_err | output | 1 | Sticky flag: a block missed its move deadline |

## Verification
The assertions assume that period ticks are spaced more than NUM_BLOCKS cycles apart, so that a tick never arrives during a running scan. They also assume that all block indices are below NUM_BLOCKS and that the mover holds req_ready as a plain accept with no other condition. The stimulus ticks only after the previous period's requests have been collected and released, and it drives indices only within the small configuration. The overflow case is provoked on purpose by holding req_ready low across two ticks.

// File: rtl/rt_pkg.sv
package rt_pkg;

   // per-block entry encoding
   typedef enum logic [1:0] {
      ENT_IDLE  = 2'd0,   // erased or holding normal-mode data
      ENT_FRESH = 2'd1,   // relaxed data written in the current period
      ENT_DUE   = 2'd2,   // must be moved during this period
      ENT_SENT  = 2'd3    // request accepted, waiting for release
   } ent_t;

endpackage

// File: rtl/rt_scan.sv
module rt_scan #(
   parameter int NUM_BLOCKS = 64,
   parameter int IDX_W      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             period_tick,
   output logic             scan_act,
   output logic [IDX_W-1:0] scan_idx
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_act <= 1'b0;
         scan_idx <= '0;
      end else if (!scan_act) begin
         if (period_tick) begin
            scan_act <= 1'b1;
            scan_idx <= '0;
         end
      end else if (scan_idx == LAST_IDX) begin
         scan_act <= 1'b0;
         scan_idx <= '0;
      end else begin
         scan_idx <= scan_idx + 1'b1;
      end
   end

endmodule

// File: rtl/rt_table.sv
module rt_table
   import rt_pkg::*;
#(
   parameter int NUM_BLOCKS = 64,
   parameter int IDX_W      = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   input  logic [IDX_W-1:0]      wr_blk,
   input  logic                  wr_first,
   input  logic                  wr_relaxed,
   input  logic                  rel_valid,
   input  logic [IDX_W-1:0]      rel_blk,
   input  logic                  scan_act,
   input  logic [IDX_W-1:0]      scan_idx,
   input  logic                  hs,
   input  logic [IDX_W-1:0]      hs_blk,
   output logic [NUM_BLOCKS-1:0] due_vec,
   output logic                  scan_miss
);

   logic [NUM_BLOCKS-1:0] miss_vec;
   logic                  wr_ev;

   assign wr_ev = wr_valid & wr_first & wr_relaxed;

   for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_ent
      ent_t st_q;
      ent_t st_d;
      logic rel_hit;
      logic wr_hit;
      logic scan_hit;
      logic hs_hit;

      assign rel_hit  = rel_valid & (rel_blk  == IDX_W'(i));
      assign wr_hit   = wr_ev     & (wr_blk   == IDX_W'(i));
      assign scan_hit = scan_act  & (scan_idx == IDX_W'(i));
      assign hs_hit   = hs        & (hs_blk   == IDX_W'(i));

      always_comb begin
         st_d = st_q;
         if (rel_hit) begin
            st_d = ENT_IDLE;
         end else if (wr_hit) begin
            if (st_q == ENT_IDLE) st_d = ENT_FRESH;
         end else if (hs_hit && st_q == ENT_DUE) begin
            st_d = ENT_SENT;
         end else if (scan_hit && st_q == ENT_FRESH) begin
            st_d = ENT_DUE;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= ENT_IDLE;
         else        st_q <= st_d;
      end

      assign due_vec[i]  = (st_q == ENT_DUE);
      assign miss_vec[i] = scan_hit & ~rel_hit & ~wr_hit &
                           ((st_q == ENT_DUE) | (st_q == ENT_SENT));
   end

   assign scan_miss = |miss_vec;

endmodule

// File: rtl/rt_pick.sv
module rt_pick #(
   parameter int NUM_BLOCKS = 64,
   parameter int IDX_W      = 6
) (
   input  logic [NUM_BLOCKS-1:0] due_vec,
   output logic                  any_due,
   output logic [IDX_W-1:0]      pick_idx
);

   assign any_due = |due_vec;

   // lowest set index wins
   always_comb begin
      pick_idx = '0;
      for (int k = NUM_BLOCKS - 1; k >= 0; k--) begin
         if (due_vec[k]) pick_idx = IDX_W'(k);
      end
   end

endmodule

// File: rtl/rt_issue.sv
module rt_issue #(
   parameter int STAGGER_CYCLES = 1000,
   parameter int IDX_W          = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_due,
   input  logic [IDX_W-1:0] pick_idx,
   input  logic             req_ready,
   output logic             req_valid,
   output logic [IDX_W-1:0] req_blk,
   output logic             hs
);

   localparam int CW = $clog2(STAGGER_CYCLES + 1);
   localparam logic [CW-1:0] RELOAD = CW'(STAGGER_CYCLES - 1);

   logic [CW-1:0] gap_q;

   assign hs = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_blk   <= '0;
         gap_q     <= '0;
      end else if (hs) begin
         req_valid <= 1'b0;
         gap_q     <= RELOAD;
      end else begin
         if (gap_q != '0) gap_q <= gap_q - 1'b1;
         if (!req_valid && gap_q == '0 && any_due) begin
            req_valid <= 1'b1;
            req_blk   <= pick_idx;
         end
      end
   end

endmodule

// File: rtl/retention_tracker.sv
module retention_tracker #(
   parameter  int NUM_BLOCKS     = 64,
   parameter  int STAGGER_CYCLES = 12_500_000,
   localparam int IDX_W          = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             period_tick,
   input  logic             wr_valid,
   input  logic [IDX_W-1:0] wr_blk,
   input  logic             wr_first,
   input  logic             wr_relaxed,
   input  logic             rel_valid,
   input  logic [IDX_W-1:0] rel_blk,
   input  logic             req_ready,
   input  logic             err_clear,
   output logic             req_valid,
   output logic [IDX_W-1:0] req_blk,
   output logic             ovf_err
);

   if (NUM_BLOCKS < 2) begin : g_bad_blocks
      $error("retention_tracker: NUM_BLOCKS must be at least 2");
   end
   if (STAGGER_CYCLES < 1) begin : g_bad_stagger
      $error("retention_tracker: STAGGER_CYCLES must be at least 1");
   end

   logic                  scan_act;
   logic [IDX_W-1:0]      scan_idx;
   logic [NUM_BLOCKS-1:0] due_vec;
   logic                  scan_miss;
   logic                  any_due;
   logic [IDX_W-1:0]      pick_idx;
   logic                  hs;

   rt_scan #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_scan (
      .clk         (clk),
      .rst_n       (rst_n),
      .period_tick (period_tick),
      .scan_act    (scan_act),
      .scan_idx    (scan_idx)
   );

   rt_table #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (wr_valid),
      .wr_blk     (wr_blk),
      .wr_first   (wr_first),
      .wr_relaxed (wr_relaxed),
      .rel_valid  (rel_valid),
      .rel_blk    (rel_blk),
      .scan_act   (scan_act),
      .scan_idx   (scan_idx),
      .hs         (hs),
      .hs_blk     (req_blk),
      .due_vec    (due_vec),
      .scan_miss  (scan_miss)
   );

   rt_pick #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_pick (
      .due_vec  (due_vec),
      .any_due  (any_due),
      .pick_idx (pick_idx)
   );

   rt_issue #(.STAGGER_CYCLES(STAGGER_CYCLES), .IDX_W(IDX_W)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_due   (any_due),
      .pick_idx  (pick_idx),
      .req_ready (req_ready),
      .req_valid (req_valid),
      .req_blk   (req_blk),
      .hs        (hs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ovf_err <= 1'b0;
      else if (scan_miss) ovf_err <= 1'b1;
      else if (err_clear) ovf_err <= 1'b0;
   end

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
   parameter int STAGGER_CYCLES = 1000,
   parameter int IDX_W          = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [IDX_W-1:0] req_blk,
   input logic             ovf_err,
   input logic             err_clear
);

   int since_hs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      since_hs <= STAGGER_CYCLES;
      else if (req_valid && req_ready) since_hs <= 0;
      else if (since_hs < STAGGER_CYCLES) since_hs <= since_hs + 1;
   end

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_blk)));

   // R4
   hs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_valid);

   // R5
   stagger_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> (since_hs >= STAGGER_CYCLES));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_err && !err_clear) |=> ovf_err);

   // R7
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_err) |-> $past(err_clear));

endmodule

bind retention_tracker rt_checker #(
   .STAGGER_CYCLES (STAGGER_CYCLES),
   .IDX_W          (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_blk   (req_blk),
   .ovf_err   (ovf_err),
   .err_clear (err_clear)
);

// File: tb/sim_retention_tracker.sv
`timescale 1ns/1ps
module sim_retention_tracker;

   localparam int NB = 8;
   localparam int S  = 6;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          period_tick = 1'b0;
   logic          wr_valid = 1'b0;
   logic [IW-1:0] wr_blk = '0;
   logic          wr_first = 1'b0;
   logic          wr_relaxed = 1'b0;
   logic          rel_valid = 1'b0;
   logic [IW-1:0] rel_blk = '0;
   logic          req_ready = 1'b0;
   logic          err_clear = 1'b0;
   logic          req_valid;
   logic [IW-1:0] req_blk;
   logic          ovf_err;

   int n_chk = 0;
   int n_bad = 0;
   int got_blk [16];
   int got_at  [16];
   int n_got;

   always #4 clk = ~clk;

   retention_tracker #(.NUM_BLOCKS(NB), .STAGGER_CYCLES(S)) u0 (
      .clk(clk), .rst_n(rst_n), .period_tick(period_tick),
      .wr_valid(wr_valid), .wr_blk(wr_blk), .wr_first(wr_first),
      .wr_relaxed(wr_relaxed), .rel_valid(rel_valid), .rel_blk(rel_blk),
      .req_ready(req_ready), .err_clear(err_clear),
      .req_valid(req_valid), .req_blk(req_blk), .ovf_err(ovf_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int blk, input bit relaxed, input bit first);
      @(negedge clk);
      wr_valid = 1'b1; wr_blk = IW'(blk); wr_relaxed = relaxed; wr_first = first;
      @(negedge clk);
      wr_valid = 1'b0; wr_relaxed = 1'b0; wr_first = 1'b0;
   endtask

   task automatic do_tick();
      @(negedge clk); period_tick = 1'b1;
      @(negedge clk); period_tick = 1'b0;
   endtask

   // tick, then accept and release every request; pri >= 0 injects a
   // relaxed first-page write to block pri in the cycle the scan reaches it
   task automatic run_period(input int exp_mask, input int pri);
      int idx;
      int len;
      len = NB + 4 + NB * (S + 1) + S;
      n_got = 0;
      do_tick();
      req_ready = 1'b1;
      for (int j = 1; j <= len; j++) begin
         @(negedge clk);
         if (j == pri) begin
            wr_valid = 1'b1; wr_blk = IW'(pri); wr_relaxed = 1'b1; wr_first = 1'b1;
         end else begin
            wr_valid = 1'b0; wr_relaxed = 1'b0; wr_first = 1'b0;
         end
         if (req_valid) begin
            if (n_got < 16) begin
               got_blk[n_got] = int'(req_blk);
               got_at[n_got]  = j;
            end
            n_got++;
            rel_valid = 1'b1; rel_blk = req_blk;
         end else begin
            rel_valid = 1'b0;
         end
      end
      @(negedge clk);
      rel_valid = 1'b0; req_ready = 1'b0;
      check("R4 request count", n_got, $countones(exp_mask));
      idx = 0;
      for (int b = 0; b < NB; b++) begin
         if (exp_mask[b] && idx < n_got && idx < 16) begin
            check("R4 ascending order", got_blk[idx], b);
            idx++;
         end
      end
      for (int k = 1; k < n_got && k < 16; k++)
         check("R5 stagger gap", got_at[k] - got_at[k-1], S + 1);
      check("R7 no overflow", int'(ovf_err), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 req_valid after reset", int'(req_valid), 0);
      check("R1 ovf_err after reset", int'(ovf_err), 0);
      run_period(0, -1);

      // R6: released fresh block is never requested
      wr(3, 1'b1, 1'b1);
      @(negedge clk); rel_valid = 1'b1; rel_blk = 3'd3;
      @(negedge clk); rel_valid = 1'b0;
      run_period(0, -1);

      // R8: rewrite while the scan examines block 7
      wr(7, 1'b1, 1'b1);
      run_period(0, 7);
      run_period(8'h80, -1);

      // R7: overflow by holding the request across a second tick
      wr(5, 1'b1, 1'b1);
      do_tick();
      repeat (NB + 3) @(negedge clk);
      check("R4 pending request valid", int'(req_valid), 1);
      check("R4 pending request block", int'(req_blk), 5);
      check("R7 no overflow yet", int'(ovf_err), 0);
      begin
         int moved = 0;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (!req_valid || req_blk != 3'd5) moved++;
         end
         check("R4 held request stable", moved, 0);
      end
      do_tick();
      repeat (NB + 2) @(negedge clk);
      check("R7 overflow set", int'(ovf_err), 1);
      repeat (3) @(negedge clk);
      check("R7 overflow sticky", int'(ovf_err), 1);
      err_clear = 1'b1;
      @(negedge clk); err_clear = 1'b0;
      check("R7 overflow cleared", int'(ovf_err), 0);
      req_ready = 1'b1; rel_valid = 1'b1; rel_blk = 3'd5;
      @(negedge clk);
      req_ready = 1'b0; rel_valid = 1'b0;
      check("R4 request dropped after handshake", int'(req_valid), 0);
      repeat (S + 2) @(negedge clk);

      // R2 R3: exhaustive sweep over which blocks hold relaxed data
      for (int m = 0; m < (1 << NB); m++) begin
         for (int b = 0; b < NB; b++) begin
            if (m[b]) begin
               wr(b, 1'b1, 1'b1);
            end else begin
               wr(b, 1'b0, 1'b1);
               wr(b, 1'b1, 1'b0);
            end
         end
         repeat (S + 2) @(negedge clk);
         check("R2 no request before tick", int'(req_valid), 0);
         run_period(m, -1);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule